// File: doc/BRIEF.md
# Run-Length Infrared Transmitter

This block drives up to two infrared emitter pins from a stream of run-length entries. Each entry names a level (mark or gap) and a length counted in sample periods. The block keeps two holding slots that fill and drain in turn. While one entry plays, the host can refill the slot that has just been freed. When an entry is taken into playback, an interrupt flag is raised so the host knows a slot is free again.

During a mark the emitters either sit at a steady high level or are keyed by a carrier. The carrier's period and high time are counted in 500 ns units, and its polarity can be inverted. The carrier restarts at the start of every mark, so each burst opens on a full cycle. A two-bit mask picks which emitters follow the waveform. On the half-duplex variant the receiver enable is forced off while a transmission is under way.

Entries arrive on a valid/ready interface. An entry is taken on a clock edge where `ent_valid` and `ent_ready` are both high. `ent_ready` is low while the slot due to be written next is still occupied, and it is also low while the mask is zero. While `ent_valid` is high and `ent_ready` is low, the host must hold `ent_data` steady.

Top module: `irtx_rl`

## Requirements
- R1: Entries are written into the two slots in turn and are played back in the same order they were accepted.
- R2: `ent_data[CNT_W]` is the level flag (1 = mark, 0 = gap) and `ent_data[CNT_W-1:0]` is the length. An entry with length N keeps `busy` high for exactly N*SAMPLE_DIV clock cycles. When the block is idle, playback starts on the edge after the entry is accepted.
- R3: Consecutive entries play with no gap between them, so a long mark split into several mark entries gives one unbroken high level.
- R4: With `mod_en`=1 and `car_pol`=0, a mark is high for `car_high`*UNIT_DIV cycles out of every `car_period`*UNIT_DIV cycles. With `mod_en`=0, a mark is a steady high.
- R5: `car_pol`=1 inverts the carrier, so a mark is low for the first `car_high`*UNIT_DIV cycles of each period and high for the rest.
- R6: The carrier phase restarts when each mark entry is loaded, so every mark opens with the high part of a full carrier cycle.
- R7: `irq` is set on the edge where an entry is taken into playback, stays set until an `irq_clr` pulse clears it, and a new set takes priority over a clear in the same cycle.
- R8: `tx_mask[0]` enables `emit[0]` and `tx_mask[1]` enables `emit[1]`. A zero mask is invalid: `ent_ready` stays low, no entry is accepted and both emitters stay low.
- R9: A zero-length entry is consumed and ends the transmission. Playback also ends when the next slot is empty. Both emitters are low whenever `busy` is low.
- R10: `ent_ready` is low while both slots hold unplayed entries, and a held entry is accepted once a slot frees.
- R11: With HALF_DUPLEX=1, `rx_en_o` is low while `busy` is high and otherwise follows `rx_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ent_valid | input | 1 | Entry offered |
| ent_ready | output | 1 | Entry can be accepted |
| ent_data | input | CNT_W+1 | Level flag (MSB) and length |
| mod_en | input | 1 | Carrier keying on marks |
| car_pol | input | 1 | Carrier polarity invert |
| car_period | input | CAR_W | Carrier period in 500 ns units |
| car_high | input | CAR_W | Carrier high time in 500 ns units |
| tx_mask | input | 2 | Emitter enables |
| irq_clr | input | 1 | Clears the done flag |
| rx_en_i | input | 1 | Receiver enable request |
| emit | output | 2 | Emitter drive |
| busy | output | 1 | Transmission in progress |
| irq | output | 1 | Entry-consumed flag |
| rx_en_o | output | 1 | Receiver enable after the half-duplex gate |

## Verification
The bench builds the block with SAMPLE_DIV=4 and UNIT_DIV=2, so one sample period is four clocks and one carrier unit is two clocks. At these values, splitting a maximum-length mark into two full 127-count entries finishes in about a thousand cycles. A 4-unit carrier with a 1-unit high time shows the duty cycle and the inverted polarity within a short mark. A 3-unit carrier with one-sample marks makes a missing phase restart change the measured high time. With CNT_W=7, the largest entry length and the zero-length terminator are both covered. HALF_DUPLEX=1 makes the receiver gate observable.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_PLAY = 1'b1
  } play_state_e;
endpackage

// File: rtl/irtx_slots.sv
module irtx_slots #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          can_push,
  output logic          head_valid,
  output logic [DW-1:0] head_data
);
  localparam int NSLOT = 2;

  logic [DW-1:0]    slot_q [NSLOT];
  logic [NSLOT-1:0] full_q;
  logic             wr_q, rd_q;
  logic [NSLOT-1:0] set_v, clr_v;

  assign can_push   = !full_q[wr_q];
  assign head_valid = full_q[rd_q];
  assign head_data  = slot_q[rd_q];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign set_v[g] = push && (wr_q == g[0]);
    assign clr_v[g] = pop  && (rd_q == g[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        slot_q[g] <= '0;
      else if (set_v[g]) slot_q[g] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      full_q <= (full_q | set_v) & ~clr_v;
      if (push) wr_q <= !wr_q;
      if (pop)  rd_q <= !rd_q;
    end
  end

  assert_pop_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> full_q[rd_q]);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full_q[wr_q]);
endmodule

// File: rtl/irtx_player.sv
module irtx_player
  import irtx_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int SAMPLE_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_valid,
  input  logic             head_pulse,
  input  logic [CNT_W-1:0] head_cnt,
  output logic             pop,
  output logic             busy,
  output logic             level_pulse,
  output logic             burst_start
);
  localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);

  play_state_e      state_q;
  logic [CNT_W-1:0] rem_q;
  logic [DIV_W-1:0] div_q;
  logic             pulse_q;
  logic             tick, last, take, load;

  assign tick = (state_q == PS_PLAY) && (div_q == DIV_LAST);
  assign last = tick && (rem_q == CNT_W'(1));
  assign take = head_valid && ((state_q == PS_IDLE) || last);
  assign load = take && (head_cnt != '0);

  assign pop         = take;
  assign busy        = (state_q == PS_PLAY);
  assign level_pulse = pulse_q;
  assign burst_start = load && head_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      rem_q   <= '0;
      div_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (load) begin
        state_q <= PS_PLAY;
        rem_q   <= head_cnt;
        div_q   <= '0;
        pulse_q <= head_pulse;
      end else begin
        if (take || last) state_q <= PS_IDLE;
        if (state_q == PS_PLAY) div_q <= tick ? '0 : div_q + DIV_W'(1);
        if (tick) rem_q <= rem_q - CNT_W'(1);
      end
    end
  end

  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem_q != '0));
  assert_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last && head_valid && (head_cnt != '0)) |=> busy);
  assert_zero_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (head_cnt == '0)) |=> !busy);
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int CAR_W    = 8,
  parameter int UNIT_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CAR_W-1:0] period,
  input  logic [CAR_W-1:0] high,
  input  logic             pol,
  output logic             wave
);
  localparam int UD_W = (UNIT_DIV > 1) ? $clog2(UNIT_DIV) : 1;
  localparam logic [UD_W-1:0] UD_LAST = UD_W'(UNIT_DIV - 1);

  logic [UD_W-1:0]  udiv_q;
  logic [CAR_W-1:0] pos_q;
  logic             utick, wrap;

  assign utick = (udiv_q == UD_LAST);
  assign wrap  = ({1'b0, pos_q} + (CAR_W+1)'(1)) >= {1'b0, period};
  assign wave  = (pos_q < high) ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      udiv_q <= '0;
      pos_q  <= '0;
    end else if (restart) begin
      udiv_q <= '0;
      pos_q  <= '0;
    end else begin
      udiv_q <= utick ? '0 : udiv_q + UD_W'(1);
      if (utick) pos_q <= wrap ? '0 : pos_q + CAR_W'(1);
    end
  end

  assert_restart_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && (high != '0)) ##1 ($stable(high) && $stable(pol)) |-> (wave == !pol));
endmodule

// File: rtl/irtx_rl.sv
module irtx_rl
  import irtx_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int SAMPLE_DIV  = 5000,
  parameter int UNIT_DIV    = 50,
  parameter int CAR_W       = 8,
  parameter bit HALF_DUPLEX = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ent_valid,
  output logic             ent_ready,
  input  logic [CNT_W:0]   ent_data,
  input  logic             mod_en,
  input  logic             car_pol,
  input  logic [CAR_W-1:0] car_period,
  input  logic [CAR_W-1:0] car_high,
  input  logic [1:0]       tx_mask,
  input  logic             irq_clr,
  input  logic             rx_en_i,
  output logic [1:0]       emit,
  output logic             busy,
  output logic             irq,
  output logic             rx_en_o
);
  localparam int DW   = CNT_W + 1;
  localparam int NEMT = 2;

  logic          can_push, push, pop, head_valid;
  logic [DW-1:0] head_data;
  logic          level_pulse, burst_start, wave, drive;
  logic          irq_q;

  assign ent_ready = can_push && (tx_mask != '0);
  assign push      = ent_valid && ent_ready;

  irtx_slots #(.DW(DW)) slots_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(ent_data), .pop(pop),
    .can_push(can_push), .head_valid(head_valid), .head_data(head_data)
  );

  irtx_player #(.CNT_W(CNT_W), .SAMPLE_DIV(SAMPLE_DIV)) player_i (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid),
    .head_pulse(head_data[CNT_W]), .head_cnt(head_data[CNT_W-1:0]),
    .pop(pop), .busy(busy), .level_pulse(level_pulse), .burst_start(burst_start)
  );

  irtx_carrier #(.CAR_W(CAR_W), .UNIT_DIV(UNIT_DIV)) carrier_i (
    .clk(clk), .rst_n(rst_n), .restart(burst_start), .period(car_period),
    .high(car_high), .pol(car_pol), .wave(wave)
  );

  assign drive = busy && level_pulse && (mod_en ? wave : 1'b1);

  for (genvar g = 0; g < NEMT; g++) begin : g_emit
    assign emit[g] = drive && tx_mask[g];
  end

  if (HALF_DUPLEX) begin : g_half
    assign rx_en_o = rx_en_i && !busy;
    assert_rx_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rx_en_o);
  end else begin : g_full
    assign rx_en_o = rx_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (pop)     irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end
  assign irq = irq_q;

  assert_irq_on_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> irq);
  assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (emit & ~tx_mask) == '0);
  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (emit == '0));
endmodule

// File: tb/irtx_rl_tb_top.sv
module irtx_rl_tb_top;
  localparam int CLK_T = 10;
  localparam int CW    = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ent_valid = 1'b0;
  logic          ent_ready;
  logic [CW:0]   ent_data = '0;
  logic          mod_en = 1'b0, car_pol = 1'b0;
  logic [7:0]    car_period = 8'd4, car_high = 8'd1;
  logic [1:0]    tx_mask = 2'b11;
  logic          irq_clr = 1'b0, rx_en_i = 1'b1;
  logic [1:0]    emit;
  logic          busy, irq, rx_en_o;

  int n_chk = 0, n_bad = 0;
  int hi0, hi1, busy_n, rise0, brise;
  logic p0, pb;
  bit done = 0;

  always #(CLK_T/2) clk = !clk;

  irtx_rl #(.CNT_W(CW), .SAMPLE_DIV(4), .UNIT_DIV(2), .CAR_W(8), .HALF_DUPLEX(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ent_data(ent_data), .mod_en(mod_en), .car_pol(car_pol),
    .car_period(car_period), .car_high(car_high), .tx_mask(tx_mask),
    .irq_clr(irq_clr), .rx_en_i(rx_en_i), .emit(emit), .busy(busy),
    .irq(irq), .rx_en_o(rx_en_o)
  );

  always @(negedge clk) begin
    hi0    <= hi0 + int'(emit[0]);
    hi1    <= hi1 + int'(emit[1]);
    busy_n <= busy_n + int'(busy);
    rise0  <= rise0 + int'(emit[0] && !p0);
    brise  <= brise + int'(busy && !pb);
    p0 <= emit[0];
    pb <= busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic clear_mon();
    @(negedge clk);
    hi0 = 0; hi1 = 0; busy_n = 0; rise0 = 0; brise = 0; p0 = 1'b0; pb = 1'b0;
  endtask

  task automatic push(input bit pulse, input int cnt);
    ent_data  = {pulse, CW'(cnt)};
    ent_valid = 1'b1;
    while (!ent_ready) @(negedge clk);
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 3) begin
      @(negedge clk);
      q = busy ? 0 : q + 1;
    end
  endtask

  task automatic t_reset();
    chk_eq("R9 reset emit", int'(emit), 0);
    chk_eq("R9 reset busy", int'(busy), 0);
    chk_eq("R7 reset irq", int'(irq), 0);
    chk_eq("R10 reset ready", int'(ent_ready), 1);
    chk_eq("R11 reset rx", int'(rx_en_o), 1);
  endtask

  task automatic t_steady();
    mod_en = 1'b0;
    clear_mon();
    push(1, 3); push(0, 2); push(1, 1);
    wait_quiet();
    chk_eq("R2 busy length", busy_n, 24);
    chk_eq("R1 mark cycles e0", hi0, 16);
    chk_eq("R1 mark cycles e1", hi1, 16);
    chk_eq("R1 mark count", rise0, 2);
    chk_eq("R3 single busy run", brise, 1);
  endtask

  task automatic t_split();
    clear_mon();
    push(1, 127); push(1, 127);
    wait_quiet();
    chk_eq("R3 split high cycles", hi0, 1016);
    chk_eq("R3 split unbroken", rise0, 1);
  endtask

  task automatic t_mask();
    tx_mask = 2'b01;
    clear_mon(); push(1, 2); wait_quiet();
    chk_eq("R8 mask01 e0", hi0, 8);
    chk_eq("R8 mask01 e1", hi1, 0);
    tx_mask = 2'b10;
    clear_mon(); push(1, 2); wait_quiet();
    chk_eq("R8 mask10 e0", hi0, 0);
    chk_eq("R8 mask10 e1", hi1, 8);
    tx_mask = 2'b00;
    clear_mon();
    chk_eq("R8 mask0 ready", int'(ent_ready), 0);
    ent_data = {1'b1, CW'(2)};
    ent_valid = 1'b1;
    repeat (10) @(negedge clk);
    ent_valid = 1'b0;
    @(negedge clk);
    tx_mask = 2'b11;
    repeat (3) @(negedge clk);
    chk_eq("R8 mask0 no start", brise, 0);
    chk_eq("R8 mask0 no output", hi0 + hi1, 0);
  endtask

  task automatic t_carrier();
    mod_en = 1'b1; car_period = 8'd4; car_high = 8'd1; car_pol = 1'b0;
    clear_mon(); push(1, 4); wait_quiet();
    chk_eq("R4 duty high", hi0, 4);
    chk_eq("R4 bursts", rise0, 2);
    chk_eq("R4 busy", busy_n, 16);
    car_pol = 1'b1;
    clear_mon(); push(1, 4); wait_quiet();
    chk_eq("R5 inverted high", hi0, 12);
    car_pol = 1'b0;
  endtask

  task automatic t_restart();
    mod_en = 1'b1; car_period = 8'd3; car_high = 8'd1; car_pol = 1'b0;
    clear_mon(); push(1, 1); push(0, 1); push(1, 1); wait_quiet();
    chk_eq("R6 restart high", hi0, 4);
    chk_eq("R6 restart bursts", rise0, 2);
    mod_en = 1'b0;
  endtask

  task automatic t_zero();
    mod_en = 1'b0;
    clear_mon(); push(1, 2); push(1, 0); push(1, 3); wait_quiet();
    chk_eq("R9 zero ends run", brise, 2);
    chk_eq("R9 zero high", hi0, 20);
    chk_eq("R9 idle low", int'(emit), 0);
  endtask

  task automatic t_irq();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
    chk_eq("R7 cleared", int'(irq), 0);
    clear_mon(); push(1, 0); wait_quiet();
    chk_eq("R7 zero entry consumed", int'(irq), 1);
    chk_eq("R9 zero entry no play", brise, 0);
    repeat (5) @(negedge clk);
    chk_eq("R7 held", int'(irq), 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
    chk_eq("R7 clear", int'(irq), 0);
  endtask

  task automatic t_backpressure();
    mod_en = 1'b0;
    clear_mon();
    push(1, 10); push(1, 1); push(1, 1);
    chk_eq("R10 both slots full", int'(ent_ready), 0);
    chk_eq("R11 rx blocked", int'(rx_en_o), 0);
    push(0, 1);
    wait_quiet();
    chk_eq("R10 all played", busy_n, 52);
    chk_eq("R10 mark cycles", hi0, 48);
    chk_eq("R11 rx restored", int'(rx_en_o), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_steady();
    t_split();
    t_mask();
    t_carrier();
    t_restart();
    t_zero();
    t_irq();
    t_backpressure();
    finish_run();
  end
endmodule